// File: doc/BRIEF.md
# Detector Status Change Interrupt Controller

This block sits between a group of modem line detectors and the host. Each clock it captures the eight-bit detector status word in a snapshot register and compares the incoming word against that snapshot. A difference in one of the interrupt-capable bits sets a sticky, active-high interrupt. The interrupt stays set until the host reads the status word, which it signals with a one-cycle read strobe.

The interrupt-capable bits are call progress, answer tone, carrier detect, unscrambled mark and S1 pattern. Which of them may fire depends on the transmitter's state. While the transmitter is on, call-progress and answer-tone changes are suppressed. While tone dialling is being sent, carrier changes are suppressed. Power-down, or a cleared interrupt enable, blocks everything. A suppressed change is dropped rather than queued, because the snapshot keeps tracking the input.

Top module: `statusIrqCtrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `irqOut` is 0 and `statusSnap` is 0.
- R2: `statusSnap` equals the value `statusIn` had at the previous rising clock edge.
- R3: With `irqEnable`=1 and `powerDown`=0, a difference between `statusIn` and `statusSnap` in bit 1 (call progress), bit 2 (answer tone), bit 3 (carrier), bit 4 (unscrambled mark) or bit 6 (S1 pattern) sets `irqOut` at the next edge, unless R6 or R7 masks that bit.
- R4: A change in bit 0 (signal quality), bit 5 (received data) or bit 7 (receive level) never sets `irqOut`.
- R5: While `irqEnable`=0, `irqOut` is 0 after the next edge and no change sets it.
- R6: While `txEnable`=1, changes in bits 1 and 2 do not set `irqOut`. Bits 3, 4 and 6 still do.
- R7: While `dtmfActive`=1, changes in bit 3 do not set `irqOut`.
- R8: While `powerDown`=1, `irqOut` is 0 after the next edge and no change sets it.
- R9: Once set, `irqOut` stays 1 until an edge with `statusRead`=1, after which it is 0.
- R10: If `statusRead`=1 in the same cycle as a qualifying change, `irqOut` stays 1.
- R11: A masked change is not remembered. Lifting the mask with the status steady leaves `irqOut` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| statusIn | input | 8 | Live detector status word |
| irqEnable | input | 1 | Interrupt enable |
| txEnable | input | 1 | Transmitter active, mutes tone detectors |
| dtmfActive | input | 1 | Tone dialling being sent, mutes carrier |
| powerDown | input | 1 | Power-down mode, blocks all interrupts |
| statusRead | input | 1 | Host read strobe for the status word |
| statusSnap | output | 8 | Registered status word seen by the host |
| irqOut | output | 1 | Sticky active-high interrupt |

## Verification
Both outputs are one register deep. A status word or control level applied before an edge is reflected in `statusSnap` and `irqOut` right after that edge. The bench therefore drives every input at a falling edge and samples at the next falling edge, one full cycle later. Each expected value is predicted from the inputs of that cycle and the previous snapshot, both of which the bench tracks itself. Multi-cycle effects, such as stickiness, a cleared read, or a lifted mask that leaves no trace, are checked as chains of these single-cycle steps.

// File: rtl/statusIrqPkg.sv
package statusIrqPkg;
  parameter int STAT_W = 8;

  localparam int B_QUALITY  = 0;
  localparam int B_CALLPROG = 1;
  localparam int B_ANSTONE  = 2;
  localparam int B_CARRIER  = 3;
  localparam int B_MARK     = 4;
  localparam int B_RXDATA   = 5;
  localparam int B_S1PAT    = 6;
  localparam int B_RXLEVEL  = 7;

  localparam logic [STAT_W-1:0] SRC_MASK  = (STAT_W'(1) << B_CALLPROG) | (STAT_W'(1) << B_ANSTONE)
                                          | (STAT_W'(1) << B_CARRIER)  | (STAT_W'(1) << B_MARK)
                                          | (STAT_W'(1) << B_S1PAT);
  localparam logic [STAT_W-1:0] TONE_MASK = (STAT_W'(1) << B_CALLPROG) | (STAT_W'(1) << B_ANSTONE);
  localparam logic [STAT_W-1:0] CARR_MASK = (STAT_W'(1) << B_CARRIER);

  typedef struct packed {
    logic blockAll;
    logic muteTone;
    logic muteCarrier;
  } gateStb_t;
endpackage

// File: rtl/statusIrqDatapath.sv
module statusIrqDatapath
  import statusIrqPkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] statusIn,
  input  gateStb_t          gate,
  output logic [STAT_W-1:0] snapOut,
  output logic              qualHit
);
  logic [STAT_W-1:0] snapReg;
  logic [STAT_W-1:0] changeVec;
  logic [STAT_W-1:0] qualVec;

  always_ff @(posedge clk) begin
    if (!rst_n) snapReg <= '0;
    else        snapReg <= statusIn;
  end

  assign changeVec = statusIn ^ snapReg;

  for (genvar i = 0; i < STAT_W; i++) begin : gBit
    if (SRC_MASK[i]) begin : gSrc
      logic toneOff, carrOff;
      assign toneOff = gate.muteTone && TONE_MASK[i];
      assign carrOff = gate.muteCarrier && CARR_MASK[i];
      assign qualVec[i] = changeVec[i] && !toneOff && !carrOff && !gate.blockAll;
    end else begin : gNone
      assign qualVec[i] = 1'b0;
    end
  end

  assign qualHit = |qualVec;
  assign snapOut = snapReg;
endmodule

// File: rtl/statusIrqControl.sv
module statusIrqControl
  import statusIrqPkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     irqEnable,
  input  logic     txEnable,
  input  logic     dtmfActive,
  input  logic     powerDown,
  input  logic     statusRead,
  input  logic     qualHit,
  output gateStb_t gate,
  output logic     irqOut
);
  logic pendReg;
  logic pendNext;

  always_comb begin
    gate.blockAll    = !irqEnable || powerDown;
    gate.muteTone    = txEnable;
    gate.muteCarrier = dtmfActive;
  end

  always_comb begin
    if (gate.blockAll)   pendNext = 1'b0;
    else if (qualHit)    pendNext = 1'b1;
    else if (statusRead) pendNext = 1'b0;
    else                 pendNext = pendReg;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pendReg <= 1'b0;
    else        pendReg <= pendNext;
  end

  assign irqOut = pendReg;
endmodule

// File: rtl/statusIrqCtrl.sv
module statusIrqCtrl
  import statusIrqPkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] statusIn,
  input  logic              irqEnable,
  input  logic              txEnable,
  input  logic              dtmfActive,
  input  logic              powerDown,
  input  logic              statusRead,
  output logic [STAT_W-1:0] statusSnap,
  output logic              irqOut
);
  gateStb_t gate;
  logic     qualHit;

  statusIrqDatapath uDp (
    .clk(clk), .rst_n(rst_n), .statusIn(statusIn), .gate(gate),
    .snapOut(statusSnap), .qualHit(qualHit)
  );

  statusIrqControl uCtl (
    .clk(clk), .rst_n(rst_n), .irqEnable(irqEnable), .txEnable(txEnable),
    .dtmfActive(dtmfActive), .powerDown(powerDown), .statusRead(statusRead),
    .qualHit(qualHit), .gate(gate), .irqOut(irqOut)
  );
endmodule

// File: rtl/statusIrqCtrl_chk.sv
module statusIrqCtrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] statusIn,
  input logic       irqEnable,
  input logic       txEnable,
  input logic       dtmfActive,
  input logic       powerDown,
  input logic       statusRead,
  input logic [7:0] statusSnap,
  input logic       irqOut
);
  AST_SNAP_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> statusSnap == $past(statusIn)); // R2
  AST_FIRE_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (irqEnable && !powerDown && !txEnable && !dtmfActive && (((statusIn ^ statusSnap) & 8'h5E) != 8'h00)) |=> irqOut); // R3
  AST_QUIET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (!irqOut && (((statusIn ^ statusSnap) & 8'h5E) == 8'h00)) |=> !irqOut); // R4
  AST_ENABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !irqEnable |=> !irqOut); // R5
  AST_TX_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (!irqOut && txEnable && (((statusIn ^ statusSnap) & 8'h58) == 8'h00)) |=> !irqOut); // R6
  AST_POWER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    powerDown |=> !irqOut); // R8
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irqOut && !statusRead && irqEnable && !powerDown) |=> irqOut); // R9
endmodule

bind statusIrqCtrl statusIrqCtrl_chk uChk (.*);

// File: tb/statusIrqCtrl_test.sv
module statusIrqCtrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] statusIn = '0;
  logic       irqEnable = 1'b0, txEnable = 1'b0, dtmfActive = 1'b0;
  logic       powerDown = 1'b0, statusRead = 1'b0;
  logic [7:0] statusSnap;
  logic       irqOut;

  int nChecks = 0;
  int nFails  = 0;
  logic [7:0] mSnap = '0;
  logic       mIrq  = 1'b0;
  bit         doneFlag = 1'b0;

  always #4 clk = ~clk;

  statusIrqCtrl uut (
    .clk(clk), .rst_n(rst_n), .statusIn(statusIn), .irqEnable(irqEnable),
    .txEnable(txEnable), .dtmfActive(dtmfActive), .powerDown(powerDown),
    .statusRead(statusRead), .statusSnap(statusSnap), .irqOut(irqOut)
  );

  function automatic logic predictIrq(logic [7:0] st, logic [7:0] sn, logic ie, logic tx,
                                      logic dt, logic pd, logic rd, logic cur);
    logic [7:0] chg;
    chg = (st ^ sn) & 8'h5E;
    if (tx) chg &= ~8'h06;
    if (dt) chg &= ~8'h08;
    if (!ie || pd)   return 1'b0;
    if (chg != 8'h0) return 1'b1;
    if (rd)          return 1'b0;
    return cur;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(logic [7:0] st, logic ie, logic tx, logic dt, logic pd, logic rd);
    statusIn = st; irqEnable = ie; txEnable = tx; dtmfActive = dt;
    powerDown = pd; statusRead = rd;
    mIrq  = predictIrq(st, mSnap, ie, tx, dt, pd, rd, mIrq);
    mSnap = st;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    statusIn = 8'hFF;
    repeat (3) @(negedge clk);
    check("R1 irq in reset", {7'b0, irqOut}, 8'h00);
    check("R1 snap in reset", statusSnap, 8'h00);
    statusIn = 8'h00;
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1 irq after reset", {7'b0, irqOut}, 8'h00);
    check("R1 snap after reset", statusSnap, 8'h00);
    mSnap = 8'h00; mIrq = 1'b0;

    step(8'hA5, 1, 0, 0, 0, 1);
    check("R2 snapshot", statusSnap, 8'hA5);
    step(8'hA5, 1, 0, 0, 0, 1);
    step(8'hA5 ^ 8'hA1, 1, 0, 0, 0, 0);
    check("R4 quiet bits", {7'b0, irqOut}, 8'h00);
    step(8'h04 ^ 8'h02, 1, 0, 0, 0, 0);
    check("R3 bit1 fires", {7'b0, irqOut}, 8'h01);
    step(8'h06, 1, 0, 0, 0, 0);
    check("R9 sticky", {7'b0, irqOut}, 8'h01);
    step(8'h06, 1, 0, 0, 0, 1);
    check("R9 read clears", {7'b0, irqOut}, 8'h00);
    step(8'h06, 1, 0, 0, 0, 0);
    step(8'h46, 1, 0, 0, 0, 1);
    check("R10 read with change", {7'b0, irqOut}, 8'h01);
    step(8'h46, 1, 0, 0, 0, 1);
    check("R9 read clears again", {7'b0, irqOut}, 8'h00);
    step(8'h42, 1, 1, 0, 0, 0);
    check("R6 answer tone muted", {7'b0, irqOut}, 8'h00);
    step(8'h40, 1, 1, 0, 0, 0);
    check("R6 call progress muted", {7'b0, irqOut}, 8'h00);
    step(8'h40, 1, 0, 0, 0, 0);
    check("R11 tx mask lifted", {7'b0, irqOut}, 8'h00);
    step(8'h50, 1, 1, 0, 0, 0);
    check("R6 mark still fires", {7'b0, irqOut}, 8'h01);
    step(8'h50, 1, 0, 0, 0, 1);
    step(8'h58, 1, 0, 1, 0, 0);
    check("R7 carrier muted", {7'b0, irqOut}, 8'h00);
    step(8'h58, 1, 0, 0, 0, 0);
    check("R11 dtmf mask lifted", {7'b0, irqOut}, 8'h00);
    step(8'h50, 1, 0, 0, 0, 0);
    check("R7 carrier fires unmuted", {7'b0, irqOut}, 8'h01);
    step(8'h50, 1, 0, 0, 1, 0);
    check("R8 power down clears", {7'b0, irqOut}, 8'h00);
    step(8'h52, 1, 0, 0, 1, 0);
    check("R8 power down blocks", {7'b0, irqOut}, 8'h00);
    step(8'h52, 1, 0, 0, 0, 0);
    check("R11 power up no stale", {7'b0, irqOut}, 8'h00);
    step(8'h50, 1, 0, 0, 0, 0);
    step(8'h50, 0, 0, 0, 0, 0);
    check("R5 disable clears", {7'b0, irqOut}, 8'h00);
    step(8'h10, 0, 0, 0, 0, 0);
    check("R5 disable blocks", {7'b0, irqOut}, 8'h00);

    for (int k = 0; k < 3000; k++) begin
      logic [7:0] st;
      st = statusIn;
      if ($urandom_range(3) == 0) st = st ^ (8'h01 << $urandom_range(7));
      step(st, ($urandom_range(9) != 0), ($urandom_range(3) == 0), ($urandom_range(4) == 0),
           ($urandom_range(11) == 0), ($urandom_range(5) == 0));
      check("R3 random irq", {7'b0, irqOut}, {7'b0, mIrq});
      check("R2 random snap", statusSnap, mSnap);
    end

    doneFlag = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule